// File: doc/BRIEF.md
# Paired-Page Associative Translation Array

This block is the storage and match core of a small translation lookaside buffer. It is fully associative, and the number of entries is a parameter. Each entry maps a pair of adjacent virtual pages, one even and one odd, to two physical frame descriptors. Each entry holds:

- a page-pair tag;
- a per-entry page mask that widens the page size;
- an address-space ID;
- a global bit that makes the entry match in every address space.

A descriptor carries a frame number, cache attributes, a dirty bit and a valid bit.

The array has six interfaces:

- **Lookup port** (combinational): returns hit, the winning index and the fields of the selected half in the same cycle.
- **Probe port**: returns the first matching index or a no-match flag.
- **Indexed write port**: loads one entry on the clock edge.
- **Indexed read port**: shows any entry's contents.
- **Flush command**: empties the table.
- **Round-robin victim pointer**: can be read and advanced, so that refill software can choose a slot.

Page-table walking and fault generation sit outside this block.

Top module: `ptlb_array`

## Requirements
- R1: An entry matches only when `lk_vpn[VPN_W-1:1]` (probe: `pr_pair`) equals the entry tag on every bit where the entry mask is 0; bits where the mask is 1 are not compared.
- R2: An entry matches only when its global bit is 1 or the request ASID equals the entry ASID.
- R3: An entry whose even and odd valid bits are both 0 never matches.
- R4: Page masks are contiguous ones from bit 0. With k ones in the winning mask, `lk_vpn[k]` selects the half: 0 selects even and 1 selects odd, and `lk_odd` reports the choice. `lk_pfn`, `lk_attr`, `lk_dirty` and `lk_valid` give that half. A half descriptor is packed as {pfn[PFN_W], attr[ATTR_W], dirty, valid}, with valid at bit 0 and dirty at bit 1. `lk_hit` is 1 on any match even when the selected half is invalid. On a miss, all lookup outputs are 0.
- R5: When several entries match, the lookup and the probe both report the lowest index.
- R6: A probe with no matching entry gives `pr_none`=1 and `pr_idx`=0. Otherwise it gives `pr_none`=0 and the matching index.
- R7: A write with `wr_idx` >= ENTRIES changes no entry.
- R8: An in-range write takes effect on the rising edge. The lookup and the read port show the new contents in the following cycle.
- R9: The read port shows the stored fields of entry `rd_idx` combinationally. It shows all zeros when `rd_idx` >= ENTRIES.
- R10: `flush` zeroes every entry and returns the victim pointer to 0 on the rising edge. It takes precedence over a write and an advance in the same cycle.
- R11: `vic_idx` shows the current victim index. With `vic_adv` high at a rising edge, it moves to the next index, and from ENTRIES-1 it wraps to 0.
- R12: After synchronous reset (`rst_n` low at a rising edge), every entry is zero and `vic_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space ID |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_idx | output | IW | Index of winning entry |
| lk_odd | output | 1 | Odd half selected |
| lk_pfn | output | PFN_W | Frame number of selected half |
| lk_attr | output | ATTR_W | Cache attribute of selected half |
| lk_dirty | output | 1 | Dirty bit of selected half |
| lk_valid | output | 1 | Valid bit of selected half |
| pr_pair | input | VPN_W-1 | Probe page-pair number |
| pr_asid | input | ASID_W | Probe address-space ID |
| pr_none | output | 1 | Probe found no entry |
| pr_idx | output | IW | Probe result index |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IW | Write index |
| wr_tag | input | VPN_W-1 | Page-pair tag to write |
| wr_mask | input | VPN_W-1 | Page mask to write |
| wr_asid | input | ASID_W | ASID to write |
| wr_glob | input | 1 | Global bit to write |
| wr_even | input | HALF_W | Even half descriptor to write |
| wr_odd | input | HALF_W | Odd half descriptor to write |
| rd_idx | input | IW | Read index |
| rd_tag | output | VPN_W-1 | Stored tag |
| rd_mask | output | VPN_W-1 | Stored mask |
| rd_asid | output | ASID_W | Stored ASID |
| rd_glob | output | 1 | Stored global bit |
| rd_even | output | HALF_W | Stored even descriptor |
| rd_odd | output | HALF_W | Stored odd descriptor |
| flush | input | 1 | Clear all entries and victim pointer |
| vic_adv | input | 1 | Advance victim pointer |
| vic_idx | output | IW | Current victim index |

## Verification
Lookup, probe and read results are combinational and are due in the same cycle as their inputs. The bench changes those inputs just after a falling edge and samples them one time unit later. Writes, flushes, pointer advances and reset are due only after the next rising edge. So the bench drives them on a falling edge, lets a rising edge pass, and samples afterwards. For R8 the sample is taken in the very cycle after the write edge. Exhaustive sweeps of every page number against four ASIDs are compared with a bench-side model built from the requirements.

// File: rtl/ptlb_pkg.sv
// Package: field layout of a half-page descriptor shared by the array and its users.
// Assumes a descriptor is packed as {pfn, attr, dirty, valid} with valid at bit 0.
package ptlb_pkg;
    localparam int HALF_VALID    = 0;
    localparam int HALF_DIRTY    = 1;
    localparam int HALF_ATTR_LSB = 2;
endpackage

// File: rtl/ptlb_match.sv
// Module: compares one stored entry against a request, under the entry's mask and global bit.
// Assumes e_live is the OR of the entry's two valid bits.
module ptlb_match #(
    parameter int PAIR_W = 11,
    parameter int ASID_W = 4
) (
    input  logic [PAIR_W-1:0] pair,
    input  logic [ASID_W-1:0] asid,
    input  logic [PAIR_W-1:0] e_tag,
    input  logic [PAIR_W-1:0] e_mask,
    input  logic [ASID_W-1:0] e_asid,
    input  logic              e_glob,
    input  logic              e_live,
    output logic              hit
);
    logic tag_eq;
    logic asid_ok;

    // Masked tag equality and address-space qualification.
    always_comb begin
        tag_eq  = ((pair ^ e_tag) & ~e_mask) == '0;
        asid_ok = e_glob || (asid == e_asid);
        hit     = e_live && tag_eq && asid_ok;
    end
endmodule

// File: rtl/ptlb_first.sv
// Module: finds the lowest set request bit and reports whether any bit is set.
// Assumes the clock and reset are used only by its checks.
module ptlb_first #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top down, so that the lowest set bit is written last.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (req[idx] && ((req & ~({N{1'b1}} << idx)) == '0))); // R5
endmodule

// File: rtl/ptlb_victim.sv
// Module: round-robin replacement pointer over N slots, with clear.
// Assumes clear has priority over adv.
module ptlb_victim #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          adv,
    output logic [IW-1:0] ptr
);
    localparam logic [IW-1:0] LAST  = IW'(N - 1);
    localparam logic [IW:0]   N_ENT = (IW + 1)'(N);

    // Step the pointer with wrap, or return it to 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    AST_VIC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, ptr} < N_ENT); // R11
    AST_VIC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clear && ptr == LAST) |=> ptr == '0); // R11
    AST_VIC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clear) |=> $stable(ptr)); // R11
    AST_VIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> ptr == '0); // R10
endmodule

// File: rtl/ptlb_array.sv
// Module: fully associative paired-page translation array with lookup, probe,
// indexed write/read, flush and a round-robin victim pointer.
// Assumes each page mask is contiguous ones from bit 0.
module ptlb_array
    import ptlb_pkg::*;
#(
    parameter int ENTRIES = 6,
    parameter int VPN_W   = 12,
    parameter int ASID_W  = 4,
    parameter int PFN_W   = 10,
    parameter int ATTR_W  = 3,
    localparam int PAIR_W = VPN_W - 1,
    localparam int HALF_W = PFN_W + ATTR_W + 2,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [IW-1:0]     lk_idx,
    output logic              lk_odd,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [ATTR_W-1:0] lk_attr,
    output logic              lk_dirty,
    output logic              lk_valid,
    input  logic [PAIR_W-1:0] pr_pair,
    input  logic [ASID_W-1:0] pr_asid,
    output logic              pr_none,
    output logic [IW-1:0]     pr_idx,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [PAIR_W-1:0] wr_tag,
    input  logic [PAIR_W-1:0] wr_mask,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_glob,
    input  logic [HALF_W-1:0] wr_even,
    input  logic [HALF_W-1:0] wr_odd,
    input  logic [IW-1:0]     rd_idx,
    output logic [PAIR_W-1:0] rd_tag,
    output logic [PAIR_W-1:0] rd_mask,
    output logic [ASID_W-1:0] rd_asid,
    output logic              rd_glob,
    output logic [HALF_W-1:0] rd_even,
    output logic [HALF_W-1:0] rd_odd,
    input  logic              flush,
    input  logic              vic_adv,
    output logic [IW-1:0]     vic_idx
);
    localparam int          PFN_LSB = HALF_ATTR_LSB + ATTR_W;
    localparam logic [IW:0] N_ENT   = (IW + 1)'(ENTRIES);

    logic [ENTRIES-1:0][PAIR_W-1:0] t_tag;
    logic [ENTRIES-1:0][PAIR_W-1:0] t_mask;
    logic [ENTRIES-1:0][ASID_W-1:0] t_asid;
    logic [ENTRIES-1:0]             t_glob;
    logic [ENTRIES-1:0][HALF_W-1:0] t_even;
    logic [ENTRIES-1:0][HALF_W-1:0] t_odd;

    logic               wr_ok;
    logic               rd_ok;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] pr_match;
    logic               lk_any;
    logic               pr_any;
    logic [IW-1:0]      lk_win;
    logic [VPN_W-1:0]   mask_ext;
    logic [VPN_W-1:0]   sel_edge;
    logic               sel_odd;
    logic [HALF_W-1:0]  half;

    // Range qualification of the indexed ports.
    always_comb begin
        wr_ok = wr_en && ({1'b0, wr_idx} < N_ENT);
        rd_ok = {1'b0, rd_idx} < N_ENT;
    end

    // Entry storage: reset and flush clear it, an in-range write loads one slot.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            t_tag  <= '0;
            t_mask <= '0;
            t_asid <= '0;
            t_glob <= '0;
            t_even <= '0;
            t_odd  <= '0;
        end else if (wr_ok) begin
            t_tag[wr_idx]  <= wr_tag;
            t_mask[wr_idx] <= wr_mask;
            t_asid[wr_idx] <= wr_asid;
            t_glob[wr_idx] <= wr_glob;
            t_even[wr_idx] <= wr_even;
            t_odd[wr_idx]  <= wr_odd;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        ptlb_match #(.PAIR_W(PAIR_W), .ASID_W(ASID_W)) u_lk_cmp (
            .pair   (lk_vpn[VPN_W-1:1]),
            .asid   (lk_asid),
            .e_tag  (t_tag[g]),
            .e_mask (t_mask[g]),
            .e_asid (t_asid[g]),
            .e_glob (t_glob[g]),
            .e_live (t_even[g][HALF_VALID] | t_odd[g][HALF_VALID]),
            .hit    (lk_match[g])
        );
        ptlb_match #(.PAIR_W(PAIR_W), .ASID_W(ASID_W)) u_pr_cmp (
            .pair   (pr_pair),
            .asid   (pr_asid),
            .e_tag  (t_tag[g]),
            .e_mask (t_mask[g]),
            .e_asid (t_asid[g]),
            .e_glob (t_glob[g]),
            .e_live (t_even[g][HALF_VALID] | t_odd[g][HALF_VALID]),
            .hit    (pr_match[g])
        );
    end

    ptlb_first #(.N(ENTRIES), .IW(IW)) u_lk_pick (
        .clk (clk), .rst_n (rst_n), .req (lk_match), .any (lk_any), .idx (lk_win)
    );
    ptlb_first #(.N(ENTRIES), .IW(IW)) u_pr_pick (
        .clk (clk), .rst_n (rst_n), .req (pr_match), .any (pr_any), .idx (pr_idx)
    );

    // Half selection from the bit just above the winning entry's mask, then output gating.
    always_comb begin
        mask_ext = {t_mask[lk_win], 1'b1};
        sel_edge = mask_ext & ~(mask_ext >> 1);
        sel_odd  = |(lk_vpn & sel_edge);
        half     = sel_odd ? t_odd[lk_win] : t_even[lk_win];
        lk_hit   = lk_any;
        lk_idx   = lk_any ? lk_win : '0;
        lk_odd   = lk_any && sel_odd;
        lk_pfn   = lk_any ? half[HALF_W-1:PFN_LSB] : '0;
        lk_attr  = lk_any ? half[PFN_LSB-1:HALF_ATTR_LSB] : '0;
        lk_dirty = lk_any && half[HALF_DIRTY];
        lk_valid = lk_any && half[HALF_VALID];
        pr_none  = !pr_any;
    end

    // Indexed read with zeros out of range.
    always_comb begin
        rd_tag  = rd_ok ? t_tag[rd_idx]  : '0;
        rd_mask = rd_ok ? t_mask[rd_idx] : '0;
        rd_asid = rd_ok ? t_asid[rd_idx] : '0;
        rd_glob = rd_ok && t_glob[rd_idx];
        rd_even = rd_ok ? t_even[rd_idx] : '0;
        rd_odd  = rd_ok ? t_odd[rd_idx]  : '0;
    end

    ptlb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
        .clk (clk), .rst_n (rst_n), .clear (flush), .adv (vic_adv), .ptr (vic_idx)
    );

    AST_OOR_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush && !wr_ok) |=> ($stable(t_tag) && $stable(t_mask) && $stable(t_asid)
            && $stable(t_glob) && $stable(t_even) && $stable(t_odd))); // R7
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !flush) |=> (t_tag[$past(wr_idx)] == $past(wr_tag)
            && t_even[$past(wr_idx)] == $past(wr_even) && t_odd[$past(wr_idx)] == $past(wr_odd))); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!lk_hit && pr_none)); // R10
endmodule

// File: tb/test_ptlb_array.sv
module test_ptlb_array;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] lk_vpn = '0;
    logic [3:0]  lk_asid = '0;
    logic        lk_hit, lk_odd, lk_dirty, lk_valid;
    logic [2:0]  lk_idx;
    logic [9:0]  lk_pfn;
    logic [2:0]  lk_attr;
    logic [10:0] pr_pair = '0;
    logic [3:0]  pr_asid = '0;
    logic        pr_none;
    logic [2:0]  pr_idx;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [10:0] wr_tag = '0, wr_mask = '0;
    logic [3:0]  wr_asid = '0;
    logic        wr_glob = 1'b0;
    logic [14:0] wr_even = '0, wr_odd = '0;
    logic [2:0]  rd_idx = '0;
    logic [10:0] rd_tag, rd_mask;
    logic [3:0]  rd_asid;
    logic        rd_glob;
    logic [14:0] rd_even, rd_odd;
    logic        flush = 1'b0;
    logic        vic_adv = 1'b0;
    logic [2:0]  vic_idx;

    int n_cmp = 0;
    int n_bad = 0;

    logic [10:0] m_tag [NE];
    logic [10:0] m_mask[NE];
    logic [3:0]  m_asid[NE];
    logic        m_glob[NE];
    logic [14:0] m_even[NE];
    logic [14:0] m_odd [NE];

    ptlb_array i_ptlb_array (
        .clk, .rst_n, .lk_vpn, .lk_asid, .lk_hit, .lk_idx, .lk_odd, .lk_pfn, .lk_attr,
        .lk_dirty, .lk_valid, .pr_pair, .pr_asid, .pr_none, .pr_idx, .wr_en, .wr_idx,
        .wr_tag, .wr_mask, .wr_asid, .wr_glob, .wr_even, .wr_odd, .rd_idx, .rd_tag,
        .rd_mask, .rd_asid, .rd_glob, .rd_even, .rd_odd, .flush, .vic_adv, .vic_idx
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired (all requirements) act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] mk_half(input logic [9:0] pfn, input logic [2:0] attr,
                                            input logic d, input logic v);
        return {pfn, attr, d, v};
    endfunction

    function automatic logic [19:0] exp_lk(input logic [11:0] vpn, input logic [3:0] asid);
        for (int i = 0; i < NE; i++) begin
            if ((m_even[i][0] || m_odd[i][0]) &&
                (((vpn[11:1] ^ m_tag[i]) & ~m_mask[i]) == 11'd0) &&
                (m_glob[i] || asid == m_asid[i])) begin
                int k = $countones(m_mask[i]);
                logic s = vpn[k];
                logic [14:0] h = s ? m_odd[i] : m_even[i];
                return {1'b1, 3'(i), s, h[14:5], h[4:2], h[1], h[0]};
            end
        end
        return 20'd0;
    endfunction

    function automatic logic [3:0] exp_pr(input logic [10:0] pair, input logic [3:0] asid);
        for (int i = 0; i < NE; i++) begin
            if ((m_even[i][0] || m_odd[i][0]) &&
                (((pair ^ m_tag[i]) & ~m_mask[i]) == 11'd0) &&
                (m_glob[i] || asid == m_asid[i]))
                return {1'b0, 3'(i)};
        end
        return 4'b1000;
    endfunction

    function automatic logic [19:0] dut_lk();
        return {lk_hit, lk_idx, lk_odd, lk_pfn, lk_attr, lk_dirty, lk_valid};
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NE; i++) begin
            m_tag[i] = '0; m_mask[i] = '0; m_asid[i] = '0;
            m_glob[i] = 1'b0; m_even[i] = '0; m_odd[i] = '0;
        end
    endtask

    // Drives one write on a falling edge, releases it just after the rising edge.
    task automatic wr(input int idx, input logic [10:0] tag, input logic [10:0] mask,
                      input logic [3:0] asid, input logic glob,
                      input logic [14:0] ev, input logic [14:0] od);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_tag = tag; wr_mask = mask;
        wr_asid = asid; wr_glob = glob; wr_even = ev; wr_odd = od;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (idx < NE) begin
            m_tag[idx] = tag; m_mask[idx] = mask; m_asid[idx] = asid;
            m_glob[idx] = glob; m_even[idx] = ev; m_odd[idx] = od;
        end
    endtask

    task automatic sweep(input string req_lk, input string req_pr);
        for (int v = 0; v < 4096; v++) begin
            for (int a = 0; a < 4; a++) begin
                lk_vpn = 12'(v); lk_asid = 4'(a);
                pr_pair = 11'(v >> 1); pr_asid = 4'(a);
                #1;
                chk(req_lk, 64'(dut_lk()), 64'(exp_lk(12'(v), 4'(a))));
                if (v[0] == 1'b0)
                    chk(req_pr, 64'({pr_none, pr_idx}), 64'(exp_pr(11'(v >> 1), 4'(a))));
            end
        end
    endtask

    task automatic rd_all(input string req);
        for (int i = 0; i < 8; i++) begin
            logic [56:0] e;
            rd_idx = 3'(i);
            #1;
            e = (i < NE) ? {m_tag[i], m_mask[i], m_asid[i], m_glob[i], m_even[i], m_odd[i]} : 57'd0;
            chk(req, 64'({rd_tag, rd_mask, rd_asid, rd_glob, rd_even, rd_odd}), 64'(e));
        end
    endtask

    task automatic adv_once();
        @(negedge clk);
        vic_adv = 1'b1;
        @(negedge clk);
        vic_adv = 1'b0;
    endtask

    initial begin
        int e;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R12: reset state
        chk("R12 victim", 64'(vic_idx), 64'd0);
        rd_all("R12 read");
        lk_vpn = 12'h042; lk_asid = 4'd0; pr_pair = 11'h021; pr_asid = 4'd0;
        #1;
        chk("R12 lookup", 64'(dut_lk()), 64'd0);
        chk("R12 probe", 64'({pr_none, pr_idx}), 64'b1000);

        // Mixed configuration: masks, global, overlap, dead entry.
        wr(0, 11'h010, 11'h000, 4'd1, 1'b0, mk_half(10'h101, 3'd1, 1'b0, 1'b1), mk_half(10'h102, 3'd2, 1'b1, 1'b1));
        wr(1, 11'h020, 11'h003, 4'd0, 1'b1, mk_half(10'h203, 3'd3, 1'b1, 1'b1), mk_half(10'h204, 3'd4, 1'b0, 1'b0));
        wr(2, 11'h021, 11'h000, 4'd2, 1'b0, mk_half(10'h305, 3'd5, 1'b1, 1'b1), mk_half(10'h306, 3'd6, 1'b1, 1'b1));
        wr(3, 11'h040, 11'h00F, 4'd3, 1'b0, mk_half(10'h3A7, 3'd7, 1'b0, 1'b1), mk_half(10'h0B8, 3'd0, 1'b1, 1'b1));
        wr(4, 11'h050, 11'h000, 4'd0, 1'b1, mk_half(10'h111, 3'd1, 1'b1, 1'b0), mk_half(10'h222, 3'd2, 1'b1, 1'b0));
        wr(5, 11'h7FF, 11'h001, 4'd0, 1'b0, mk_half(10'h333, 3'd3, 1'b0, 1'b0), mk_half(10'h3FE, 3'd6, 1'b1, 1'b1));

        sweep("R1 R2 R3 R4 R5 lookup", "R5 R6 probe");
        rd_all("R9 read");

        // R7: out-of-range writes that would otherwise match
        wr(6, 11'h100, 11'h000, 4'd0, 1'b1, mk_half(10'h3FF, 3'd7, 1'b1, 1'b1), mk_half(10'h3FF, 3'd7, 1'b1, 1'b1));
        wr(7, 11'h101, 11'h000, 4'd0, 1'b1, mk_half(10'h3FF, 3'd7, 1'b1, 1'b1), mk_half(10'h3FF, 3'd7, 1'b1, 1'b1));
        lk_vpn = 12'h200; lk_asid = 4'd0; pr_pair = 11'h101; pr_asid = 4'd0;
        #1;
        chk("R7 lookup", 64'(dut_lk()), 64'd0);
        chk("R7 probe", 64'({pr_none, pr_idx}), 64'b1000);
        rd_all("R7 read");

        // R8: rewrite entry 2, check in the next cycle
        wr(2, 11'h300, 11'h000, 4'd0, 1'b1, mk_half(10'h155, 3'd2, 1'b1, 1'b1), mk_half(10'h2AA, 3'd5, 1'b0, 1'b1));
        lk_vpn = 12'h601; lk_asid = 4'd3; pr_pair = 11'h300; pr_asid = 4'd1; rd_idx = 3'd2;
        #1;
        chk("R8 lookup", 64'(dut_lk()), 64'(exp_lk(12'h601, 4'd3)));
        chk("R8 lookup value", 64'(dut_lk()), 64'({1'b1, 3'd2, 1'b1, 10'h2AA, 3'd5, 1'b0, 1'b1}));
        chk("R8 probe", 64'({pr_none, pr_idx}), 64'({1'b0, 3'd2}));
        chk("R8 read", 64'({rd_tag, rd_even}), 64'({11'h300, mk_half(10'h155, 3'd2, 1'b1, 1'b1)}));

        // R11: advance with wrap
        e = 0;
        for (int n = 0; n < 14; n++) begin
            adv_once();
            e = (e + 1) % NE;
            chk("R11 victim step", 64'(vic_idx), 64'(e));
        end

        // R10: flush together with advance and an in-range write
        @(negedge clk);
        flush = 1'b1; vic_adv = 1'b1; wr_en = 1'b1; wr_idx = 3'd0;
        wr_tag = 11'h055; wr_glob = 1'b1; wr_even = mk_half(10'h001, 3'd1, 1'b1, 1'b1);
        @(negedge clk);
        flush = 1'b0; vic_adv = 1'b0; wr_en = 1'b0;
        model_clear();
        chk("R10 victim", 64'(vic_idx), 64'd0);
        rd_all("R10 read");
        sweep("R10 lookup", "R10 probe");

        adv_once();
        chk("R11 after flush", 64'(vic_idx), 64'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule